// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit takes one IEEE-754 single-precision operand per cycle and, one clock later, returns a coarse estimate of its reciprocal in the same format, together with three exception flags: invalid, divide-by-zero and underflow. The estimate is not a true quotient. It comes from a fixed 8-bit lookup whose contents are defined by a closed-form rounding rule, and its exponent comes from a fixed subtraction. Software or a downstream refinement stage can therefore rely on the result being bit-exact and reproducible.

The operand is split into sign, exponent and fraction. Special classes are resolved first, in a strict order: NaN, then infinity, then zero or denormal, then very large normals. Every other normal operand uses the top eight fraction bits to index a 256-entry table. The table is filled at elaboration from integer arithmetic. The result carries the input sign, a mirrored exponent and the table byte as the leading fraction bits.

Top module: `recip_est`

## Requirements
- R1: While reset is asserted and after its release, before any operand is accepted, `out_valid`, `out_res` and all three flags are zero.
- R2: An operand presented with `in_valid` high produces `out_valid` high on the following clock edge, with exactly one cycle of latency. When `in_valid` is low, `out_valid` goes low and `out_res` and the flags hold their previous values.
- R3: A NaN operand (exponent field 255, fraction nonzero) is returned unchanged except that fraction bit 22, the quiet bit, is forced to 1. `out_invalid` is raised only when that input bit was 0, which marks a signaling NaN.
- R4: An infinite operand (exponent field 255, fraction zero) returns zero with the operand's sign and raises no flag.
- R5: An operand with exponent field 0 (zero or denormal) returns infinity with the operand's sign (exponent field 255, fraction zero) and raises `out_divzero`.
- R6: A normal operand with exponent field 253 or 254 returns zero with the operand's sign and raises `out_underflow`.
- R7: An exponent field of 255 always selects the NaN or infinity outcome and never the underflow outcome. A NaN is never treated as infinity.
- R8: For a normal operand with exponent field e in 1..252, the result sign equals the operand sign, the result exponent field is 253 − e, and no flag is raised.
- R9: For such an operand, let q = 256 + fraction[22:15]. Result fraction bits [22:15] are the low 8 bits of s = floor(256·512/(q + 0.5) + 0.5), and result fraction bits [14:0] are zero. Operand fraction bits [14:0] have no effect on the result.
- R10: At most one flag is set at a time, and the flags belong to the same output cycle as the result they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_res | output | 32 | Single-precision reciprocal estimate |
| out_invalid | output | 1 | Operand was a signaling NaN |
| out_divzero | output | 1 | Operand was zero or denormal |
| out_underflow | output | 1 | Operand exponent field was 253 or 254 |

## Verification
The only state is the output register, so a fault in classification or table content appears at the ports on the very next cycle after the offending operand. A wrong table entry changes only the eight leading fraction bits, and only for operands whose top fraction byte selects that entry. For that reason every one of the 256 indices is driven at least once, each with scrambled low fraction bits. A misordered special-case ladder shows up as a wrong flag or a wrong exponent field for exponent 255, and a broken hold path shows up as `out_res` changing while `out_valid` is low.

// File: rtl/recip_pkg.sv
package recip_pkg;

    typedef enum logic [2:0] {
        CLS_NORM,
        CLS_NAN,
        CLS_INF,
        CLS_ZERO,
        CLS_BIG
    } op_class_e;

    // Rounded estimate for table row q: floor(2^(2k+1)/(q+0.5) + 0.5),
    // computed as ((2^(2k+3) div (2q+1)) + 1) div 2 in integers.
    function automatic int unsigned est_entry(int unsigned q, int unsigned idx_w);
        longint unsigned num;
        longint unsigned quo;
        num = 64'd1 << (2 * idx_w + 3);
        quo = num / (2 * longint'(q) + 1);
        return int'((quo + 1) >> 1);
    endfunction

endpackage

// File: rtl/recip_classify.sv
module recip_classify
    import recip_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IDX_W  = 8
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output op_class_e             cls,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_f,
    output logic [IDX_W-1:0]      idx,
    output logic                  snan
);
    localparam int W       = 1 + EXP_W + FRAC_W;
    localparam int EXP_LIM = (1 << EXP_W) - 3;

    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_nz;
    logic              big;

    always_comb begin
        frac     = op[FRAC_W-1:0];
        exp_f    = op[FRAC_W +: EXP_W];
        sign     = op[W-1];
        idx      = frac[FRAC_W-1 -: IDX_W];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac;
        big      = exp_f >= EXP_W'(EXP_LIM);
        snan     = exp_ones & frac_nz & ~frac[FRAC_W-1];

        // Ladder order matters: all-ones exponent also satisfies 'big'.
        if (exp_ones && frac_nz) begin
            cls = CLS_NAN;
        end else if (exp_ones) begin
            cls = CLS_INF;
        end else if (exp_zero) begin
            cls = CLS_ZERO;
        end else if (big) begin
            cls = CLS_BIG;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/recip_table.sv
module recip_table
    import recip_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] est
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        localparam int unsigned ROW_S = est_entry(DEPTH + i, IDX_W);
        // Leading one of ROW_S is implicit, only the low bits are stored.
        assign rom[i] = IDX_W'(ROW_S);
    end

    assign est = rom[idx];

endmodule

// File: rtl/recip_est.sv
module recip_est
    import recip_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IDX_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] in_op,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] out_res,
    output logic                  out_invalid,
    output logic                  out_divzero,
    output logic                  out_underflow
);
    localparam int W       = 1 + EXP_W + FRAC_W;
    localparam int LOW_W   = FRAC_W - IDX_W;
    localparam int EXP_LIM = (1 << EXP_W) - 3;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         inv;
        logic         dz;
        logic         uf;
    } state_t;

    state_t st_d, st_q;

    op_class_e        cls;
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [IDX_W-1:0] idx;
    logic             snan;
    logic [IDX_W-1:0] est;
    logic [EXP_W-1:0] res_exp;

    recip_classify #(
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W),
        .IDX_W (IDX_W)
    ) u_cls (
        .op   (in_op),
        .cls  (cls),
        .sign (sgn),
        .exp_f(ex),
        .idx  (idx),
        .snan (snan)
    );

    recip_table #(
        .IDX_W(IDX_W)
    ) u_tbl (
        .idx(idx),
        .est(est)
    );

    always_comb begin
        res_exp  = EXP_W'(EXP_LIM) - ex;
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.inv = 1'b0;
            st_d.dz  = 1'b0;
            st_d.uf  = 1'b0;
            unique case (cls)
                CLS_NAN: begin
                    st_d.res = in_op | (W'(1) << (FRAC_W - 1));
                    st_d.inv = snan;
                end
                CLS_INF: begin
                    st_d.res = {sgn, {(W-1){1'b0}}};
                end
                CLS_ZERO: begin
                    st_d.res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    st_d.dz  = 1'b1;
                end
                CLS_BIG: begin
                    st_d.res = {sgn, {(W-1){1'b0}}};
                    st_d.uf  = 1'b1;
                end
                default: begin
                    st_d.res = {sgn, res_exp, est, {LOW_W{1'b0}}};
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.vld;
    assign out_res       = st_q.res;
    assign out_invalid   = st_q.inv;
    assign out_divzero   = st_q.dz;
    assign out_underflow = st_q.uf;

endmodule

// File: rtl/recip_est_chk.sv
module recip_est_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IDX_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_sign,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] out_res,
    input logic                  out_invalid,
    input logic                  out_divzero,
    input logic                  out_underflow
);
    localparam int LOW_W   = FRAC_W - IDX_W;
    localparam int EXP_LIM = (1 << EXP_W) - 3;

    logic [EXP_W-1:0] o_exp;
    logic             any_flag;
    assign o_exp    = out_res[FRAC_W +: EXP_W];
    assign any_flag = out_invalid | out_divzero | out_underflow;

    // R2
    latency_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res));

    // R10
    single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_invalid, out_divzero, out_underflow}));

    // R3
    quiet_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (&o_exp && out_res[FRAC_W-1]));

    // R5
    divzero_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_divzero) |-> (&o_exp && out_res[FRAC_W-1:0] == '0));

    // R6
    underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_underflow) |-> (out_res[EXP_W+FRAC_W-1:0] == '0));

    // R8
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_res[EXP_W+FRAC_W] == $past(in_sign)));

    // R9
    normal_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !any_flag && o_exp != '0 && !(&o_exp))
        |-> (out_res[LOW_W-1:0] == '0 && o_exp < EXP_W'(EXP_LIM)));

endmodule

bind recip_est recip_est_chk #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sign      (in_op[EXP_W+FRAC_W]),
    .out_valid    (out_valid),
    .out_res      (out_res),
    .out_invalid  (out_invalid),
    .out_divzero  (out_divzero),
    .out_underflow(out_underflow)
);

// File: tb/sim_recip_est.sv
module sim_recip_est;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_op = '0;
    logic        out_valid;
    logic [31:0] out_res;
    logic        out_invalid;
    logic        out_divzero;
    logic        out_underflow;

    int checks = 0;
    int fails  = 0;
    logic        done = 1'b0;
    logic [31:0] last_res = '0;

    typedef struct {
        logic [31:0] res;
        logic        inv;
        logic        dz;
        logic        uf;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    recip_est u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_op        (in_op),
        .out_valid    (out_valid),
        .out_res      (out_res),
        .out_invalid  (out_invalid),
        .out_divzero  (out_divzero),
        .out_underflow(out_underflow)
    );

    // Behavioural reference built from real arithmetic.
    function automatic exp_t model(logic [31:0] op, string tag);
        exp_t e;
        logic [7:0]  ef = op[30:23];
        logic [22:0] f  = op[22:0];
        logic        sg = op[31];
        real a, qr, r;
        int s;
        e.res = '0; e.inv = 0; e.dz = 0; e.uf = 0; e.tag = tag;
        if (ef == 8'hFF && f != 0) begin
            e.res = op | 32'h0040_0000;
            e.inv = ~op[22];
        end else if (ef == 8'hFF) begin
            e.res = {sg, 31'b0};
        end else if (ef == 8'h00) begin
            e.res = {sg, 8'hFF, 23'b0};
            e.dz  = 1'b1;
        end else if (ef >= 8'd253) begin
            e.res = {sg, 31'b0};
            e.uf  = 1'b1;
        end else begin
            a  = 0.5 + real'(f) / 16777216.0;
            qr = $floor(a * 512.0);
            r  = 1.0 / ((qr + 0.5) / 512.0);
            s  = int'($floor(256.0 * r + 0.5));
            e.res = {sg, 8'(253 - int'(ef)), s[7:0], 15'b0};
        end
        return e;
    endfunction

    task automatic send(logic [31:0] op, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        sb.push_back(model(op, tag));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(logic ok, string tag, logic [35:0] act, logic [35:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", {3'b0, out_valid, out_res}, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_res == e.res && out_invalid == e.inv &&
                      out_divzero == e.dz && out_underflow == e.uf, e.tag,
                      {1'b0, out_invalid, out_divzero, out_underflow, out_res},
                      {1'b0, e.inv, e.dz, e.uf, e.res});
                last_res = out_res;
            end
        end
    end

    initial begin
        #1_000_000;
        $display("FAIL watchdog expired actual=running expected=finished");
        checks++;
        fails++;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check({out_valid, out_res, out_invalid, out_divzero, out_underflow} == '0,
              "R1 during reset", {out_valid, out_invalid, out_divzero, out_underflow, out_res}, '0);
        rst_n = 1'b1;
        idle(2);
        check({out_valid, out_res, out_invalid, out_divzero, out_underflow} == '0,
              "R1 after release", {out_valid, out_invalid, out_divzero, out_underflow, out_res}, '0);

        // R3 NaN handling, R10 flag alignment
        send(32'h7FC0_0001, "R3 quiet NaN passes");
        send(32'h7F80_0001, "R3/R10 signaling NaN");
        send(32'hFFA0_0000, "R3 negative signaling NaN");
        send(32'h7FFF_FFFF, "R7 exp255 is NaN not underflow");
        // R4 infinities
        send(32'h7F80_0000, "R4 +inf");
        send(32'hFF80_0000, "R4/R7 -inf");
        // R5 zero and denormal
        send(32'h0000_0000, "R5 +zero");
        send(32'h8000_0000, "R5 -zero");
        send(32'h0000_0001, "R5 denormal");
        send(32'h807F_FFFF, "R5/R10 negative denormal");
        // R6 large exponents
        send(32'h7E80_0000, "R6 exp253");
        send(32'hFF7F_FFFF, "R6 exp254 negative");
        // R8 exponent boundaries
        send(32'h0080_0000, "R8 exp1");
        send(32'hFE00_0000, "R8 exp252 negative");
        send(32'h3F80_0000, "R8 one");
        idle(2);

        // R9 every table index with scrambled low bits
        for (int i = 0; i < 256; i++) begin
            logic [14:0] lo;
            logic [7:0]  ex;
            lo = 15'((i * 2731 + 123) & 32'h7FFF);
            ex = 8'(1 + (i * 97) % 252);
            send({i[0], ex, i[7:0], lo}, "R9 table index");
            if (i % 37 == 36) idle(1);
        end
        // R9 low fraction bits have no effect
        send(32'h4012_0000, "R9 low bits zero");
        send(32'h4012_7FFF, "R9 low bits ones");
        idle(3);

        // R2 hold while idle
        in_op = 32'h1234_5678;
        idle(3);
        check(out_valid == 1'b0 && out_res == last_res, "R2 hold while idle",
              {3'b0, out_valid, out_res}, {4'b0, last_res});
        check(sb.size() == 0, "R2 all results delivered",
              36'(sb.size()), '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule